// File: doc/BRIEF.md
# Floating-point exception status register

This block is the 32-bit status and control word that sits next to a floating-point unit. It collects the exception events that the arithmetic datapath reports when an operation completes. For each of five exception classes it keeps a trap enable, a sticky flag and a per-operation cause bit. It also holds a cause bit for operations the unit cannot execute, a summary bit, a flush-to-zero control for denormal operands and a 2-bit rounding-mode field. Software reads and writes the word through a simple register port. The datapath pulses `op_done` with the exception vector of the operation that just finished.

The cause bits describe only the most recent operation. Each completion replaces them with that operation's exceptions. A sticky flag records a class only when that class's trap is masked, and it stays set until software clears it. When a completing operation raises an enabled class, or is unimplemented, the block sends a one-cycle trap request to the exception logic.

The bench builds the block with its default reset parameters. With these, the flush-to-zero bit is 1 after reset and the rounding mode is 0.

Top module: `fpsr_ctl`

## Requirements
- R1: After reset the word reads 0x0000_0100: flush-to-zero (bit 8) is 1, every other bit is 0, and `trap_req` is low.
- R2: On `op_done`, each class raised in `op_exc` whose enable is 0 sets its sticky flag. The flags are bit 30 inexact, bit 29 underflow, bit 28 divide-by-zero, bit 27 overflow and bit 26 invalid. In `op_exc`, bit 4 is inexact, bit 3 underflow, bit 2 divide-by-zero, bit 1 overflow and bit 0 invalid.
- R3: A class raised while its enable is 1 leaves its sticky flag unchanged. The enables are bits 14..10, in the same class order as the flags.
- R4: A sticky flag stays at 1 across later operations and changes only when software writes it. If a software write and a hardware set reach the same flag in the same cycle, the flag ends at 1.
- R5: Bit 31 is read-only. It reads as the OR of the underflow, divide-by-zero, overflow and invalid flags, and it is 0 when only the inexact flag is set.
- R6: On every `op_done` the cause bits are loaded in that same cycle with the new operation's exceptions, and older causes are dropped. Bit 7 takes `op_unimpl`, and bits 6..2 take inexact, underflow, divide-by-zero, overflow and invalid, in that order.
- R7: `trap_req` is high for exactly the one cycle after an `op_done` whose exceptions include an enabled class or `op_unimpl`. At all other times it is low.
- R8: The enables (bits 14..10), flush-to-zero (bit 8) and the rounding mode (bits 1..0) read back the last value software wrote to them.
- R9: Bits 25..15 and bit 9 always read 0, whatever software writes to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register word |
| op_done | input | 1 | Floating-point operation completed this cycle |
| op_exc | input | 5 | Exceptions of the completing operation (4 inexact .. 0 invalid) |
| op_unimpl | input | 1 | Completing operation is unimplemented |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench builds the block with its default parameters: flush-to-zero resets to 1 and the rounding mode resets to 0, so the reset check expects exactly 0x0000_0100. These defaults let the bench run every scenario from a known word. The scenarios are:
- masked exceptions and enabled exceptions;
- a write of all ones, which shows which bits hold state;
- a software clear and a hardware set of the same flag in one cycle;
- a run of operations in which the cause bits are replaced while the flags accumulate.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int NUM_CLS    = 5;
    localparam int WORD_W     = 32;
    localparam int SUM_BIT    = 31;
    localparam int FLAG_LSB   = 26;
    localparam int EN_LSB     = 10;
    localparam int FTZ_BIT    = 8;
    localparam int UNIMPL_BIT = 7;
    localparam int CAUSE_LSB  = 2;
    localparam int RM_W       = 2;
    localparam int RM_LSB     = 0;

    typedef struct packed {
        logic flag;
        logic en;
        logic cause;
    } cls_state_t;

    typedef struct packed {
        logic            ftz;
        logic [RM_W-1:0] rm;
        logic            unimpl;
    } mode_state_t;
endpackage

// File: rtl/fpsr_class_slice.sv
module fpsr_class_slice
    import fpsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  logic wr_flag,
    input  logic wr_en,
    input  logic wr_cause,
    input  logic op_done,
    input  logic exc,
    output logic flag_o,
    output logic en_o,
    output logic cause_o,
    output logic hit_o
);
    cls_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_we) begin
            st_d.flag  = wr_flag;
            st_d.en    = wr_en;
            st_d.cause = wr_cause;
        end
        if (op_done) begin
            st_d.cause = exc;
            // hardware set overrides a same-cycle software clear
            if (exc && !st_q.en) st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o  = st_q.flag;
    assign en_o    = st_q.en;
    assign cause_o = st_q.cause;
    assign hit_o   = op_done & exc & st_q.en;
endmodule

// File: rtl/fpsr_mode_reg.sv
module fpsr_mode_reg
    import fpsr_pkg::*;
#(
    parameter logic            RESET_FTZ = 1'b1,
    parameter logic [RM_W-1:0] RESET_RM  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic            wr_ftz,
    input  logic [RM_W-1:0] wr_rm,
    input  logic            wr_unimpl,
    input  logic            op_done,
    input  logic            op_unimpl,
    output logic            ftz_o,
    output logic [RM_W-1:0] rm_o,
    output logic            unimpl_o
);
    mode_state_t md_d, md_q;

    always_comb begin
        md_d = md_q;
        if (sw_we) begin
            md_d.ftz    = wr_ftz;
            md_d.rm     = wr_rm;
            md_d.unimpl = wr_unimpl;
        end
        if (op_done) md_d.unimpl = op_unimpl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= '{ftz: RESET_FTZ, rm: RESET_RM, unimpl: 1'b0};
        else        md_q <= md_d;
    end

    assign ftz_o    = md_q.ftz;
    assign rm_o     = md_q.rm;
    assign unimpl_o = md_q.unimpl;
endmodule

// File: rtl/fpsr_ctl.sv
module fpsr_ctl
    import fpsr_pkg::*;
#(
    parameter logic            RESET_FTZ = 1'b1,
    parameter logic [RM_W-1:0] RESET_RM  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic              op_done,
    input  logic [NUM_CLS-1:0] op_exc,
    input  logic              op_unimpl,
    output logic              trap_req
);
    logic [NUM_CLS-1:0] flag_v, en_v, cause_v, hit_v;
    logic               ftz, unimpl_c;
    logic [RM_W-1:0]    rm;
    logic               trap_d, trap_q;
    logic               unused_rsvd;

    for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
        fpsr_class_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_we    (sw_we),
            .wr_flag  (sw_wdata[FLAG_LSB+i]),
            .wr_en    (sw_wdata[EN_LSB+i]),
            .wr_cause (sw_wdata[CAUSE_LSB+i]),
            .op_done  (op_done),
            .exc      (op_exc[i]),
            .flag_o   (flag_v[i]),
            .en_o     (en_v[i]),
            .cause_o  (cause_v[i]),
            .hit_o    (hit_v[i])
        );
    end

    fpsr_mode_reg #(
        .RESET_FTZ (RESET_FTZ),
        .RESET_RM  (RESET_RM)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (sw_we),
        .wr_ftz    (sw_wdata[FTZ_BIT]),
        .wr_rm     (sw_wdata[RM_LSB +: RM_W]),
        .wr_unimpl (sw_wdata[UNIMPL_BIT]),
        .op_done   (op_done),
        .op_unimpl (op_unimpl),
        .ftz_o     (ftz),
        .rm_o      (rm),
        .unimpl_o  (unimpl_c)
    );

    assign unused_rsvd = ^{sw_wdata[SUM_BIT], sw_wdata[FLAG_LSB-1:EN_LSB+NUM_CLS],
                           sw_wdata[FTZ_BIT+1]};

    always_comb begin
        trap_d = (|hit_v) | (op_done & op_unimpl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= trap_d;
    end

    always_comb begin
        sw_rdata = '0;
        // inexact flag (top class) is left out of the summary
        sw_rdata[SUM_BIT]                   = |flag_v[NUM_CLS-2:0];
        sw_rdata[FLAG_LSB +: NUM_CLS]       = flag_v;
        sw_rdata[EN_LSB +: NUM_CLS]         = en_v;
        sw_rdata[FTZ_BIT]                   = ftz;
        sw_rdata[UNIMPL_BIT]                = unimpl_c;
        sw_rdata[CAUSE_LSB +: NUM_CLS]      = cause_v;
        sw_rdata[RM_LSB +: RM_W]            = rm;
    end

    assign trap_req = trap_q;
endmodule

// File: rtl/fpsr_ctl_checker.sv
module fpsr_ctl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_we,
    input logic        op_done,
    input logic [4:0]  op_exc,
    input logic        op_unimpl,
    input logic [31:0] sw_rdata,
    input logic        trap_req
);
    AST_MASKED_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> ((sw_rdata[30:26] & $past(op_exc & ~sw_rdata[14:10]))
                     == $past(op_exc & ~sw_rdata[14:10]))); // R2

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_we) |-> ((sw_rdata[30:26] & $past(sw_rdata[30:26]))
                           == $past(sw_rdata[30:26]))); // R4

    AST_SUMMARY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_rdata[31]) |-> $past(sw_we)); // R5

    AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (sw_rdata[6:2] == $past(op_exc)) && (sw_rdata[7] == $past(op_unimpl))); // R6

    AST_TRAP_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_done)); // R7

    AST_TRAP_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && (((op_exc & sw_rdata[14:10]) != 5'd0) || op_unimpl)) |=> trap_req); // R7
endmodule

bind fpsr_ctl fpsr_ctl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_we),
    .op_done   (op_done),
    .op_exc    (op_exc),
    .op_unimpl (op_unimpl),
    .sw_rdata  (sw_rdata),
    .trap_req  (trap_req)
);

// File: tb/fpsr_ctl_bench.sv
module fpsr_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_unimpl = 1'b0;
    logic        trap_req;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    fpsr_ctl u_fpsr_ctl (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .op_done(op_done), .op_exc(op_exc),
        .op_unimpl(op_unimpl), .trap_req(trap_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0; sw_wdata = '0;
    endtask

    task automatic fp_op(input logic [4:0] e, input logic u);
        @(negedge clk);
        op_done = 1'b1; op_exc = e; op_unimpl = u;
        @(negedge clk);
        op_done = 1'b0; op_exc = '0; op_unimpl = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset word", sw_rdata, 32'h0000_0100);
        chk("R1 reset trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_summary_inexact();
        do_reset();
        fp_op(5'b10000, 1'b0);
        chk("R5 inexact only, summary low", sw_rdata, 32'h4000_0140);
        chk("R7 masked no trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_sticky();
        do_reset();
        fp_op(5'b01000, 1'b0);
        chk("R2 underflow flag", sw_rdata, 32'hA000_0120);
        fp_op(5'b00000, 1'b0);
        chk("R4 flag kept, R6 causes cleared", sw_rdata, 32'hA000_0100);
        fp_op(5'b00010, 1'b0);
        chk("R4 flags accumulate", sw_rdata, 32'hA800_0108);
        sw_write(32'h0000_0100);
        chk("R4 software clear, R5 summary drops", sw_rdata, 32'h0000_0100);
    endtask

    task automatic t_cause_replace();
        do_reset();
        fp_op(5'b00001, 1'b0);
        chk("R6 invalid cause", sw_rdata, 32'h8400_0104);
        fp_op(5'b10000, 1'b0);
        chk("R6 cause replaced", sw_rdata, 32'hC400_0140);
    endtask

    task automatic t_unmasked();
        do_reset();
        sw_write(32'h0000_1100);
        @(negedge clk);
        op_done = 1'b1; op_exc = 5'b00100;
        @(negedge clk);
        op_done = 1'b0; op_exc = '0;
        chk("R3 enabled dz no flag", sw_rdata, 32'h0000_1110);
        chk("R7 trap raised", {31'd0, trap_req}, 32'd1);
        @(negedge clk);
        chk("R7 trap one cycle", {31'd0, trap_req}, 32'd0);
        sw_write(32'h0000_7C00);
        fp_op(5'b11111, 1'b0);
        chk("R3 all enabled no flags", sw_rdata, 32'h0000_7C7C);
        chk("R7 trap all enabled", {31'd0, trap_req}, 32'd1);
    endtask

    task automatic t_unimpl();
        do_reset();
        fp_op(5'b00000, 1'b1);
        chk("R6 unimpl cause", sw_rdata, 32'h0000_0180);
        chk("R7 unimpl traps", {31'd0, trap_req}, 32'd1);
    endtask

    task automatic t_race();
        do_reset();
        fp_op(5'b10000, 1'b0);
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = 32'h0; op_done = 1'b1; op_exc = 5'b00100;
        @(negedge clk);
        sw_we = 1'b0; op_done = 1'b0; op_exc = '0;
        chk("R4 hw set wins over sw clear", sw_rdata, 32'h9000_0010);
    endtask

    task automatic t_fields();
        do_reset();
        sw_write(32'hFFFF_FFFF);
        chk("R9 reserved zero, R8 fields", sw_rdata, 32'hFC00_7DFF);
        sw_write(32'h0000_0002);
        chk("R8 rounding mode and ftz", sw_rdata, 32'h0000_0002);
        sw_write(32'h0203_8200);
        chk("R9 reserved-only write", sw_rdata, 32'h0000_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_summary_inexact();
        t_sticky();
        t_cause_replace();
        t_unmasked();
        t_unimpl();
        t_race();
        t_fields();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule